// File: doc/BRIEF.md
# Internal Profile Burst Sequencer

This block takes over profile selection for a RAM-driven waveform engine so that a composite sweep can run without any activity on the external profile-select pins. A 3-bit control code chooses how many profiles take part (two, three or four, always starting from profile 0) and whether the order runs once or loops forever. The sequencer moves to the next profile each time the RAM address generator signals that it has reached the final address of the current segment.

While the sequencer is engaged, it drives the profile select itself and raises an override that forces every profile to run as a ramp-up segment, whatever mode that profile holds. When it is not engaged, the external profile pins pass straight through. A new control code is captured only on the update strobe, and each strobe starts the order again at profile 0. After a single burst finishes, the select holds on the last profile and a completion flag stays high until the next strobe. The sequencer acts only in RAM mode. Outside RAM mode it is transparent and keeps its state.

Top module: `profile_burst_seq`

## Requirements
- R1: After reset the sequencer is disengaged: `force_ramp_up` and `burst_done` are 0 and `profile_sel` equals `ext_profile`.
- R2: When the captured code is 3'b000 or 3'b111, the sequencer is disengaged: `profile_sel` follows `ext_profile`, and `force_ramp_up` and `burst_done` are 0.
- R3: `ctrl_code` is captured only in a cycle where `update_strobe` is 1. A change of `ctrl_code` at any other time has no effect on the outputs.
- R4: An `update_strobe` that captures a code from 3'b001 to 3'b110 sets `profile_sel` to 0 and `burst_done` to 0 from the next cycle.
- R5: While engaged, a `seg_done` pulse on a profile that is not the last one increases `profile_sel` by one in the next cycle. With no `seg_done` pulse, `profile_sel` holds.
- R6: Codes 3'b001, 3'b010 and 3'b011 run once, with profiles 1, 2 and 3 as the last profile. A `seg_done` pulse on the last profile keeps `profile_sel` there and sets `burst_done` to 1. It stays 1 until the next strobe.
- R7: Codes 3'b100, 3'b101 and 3'b110 loop, with profiles 1, 2 and 3 as the last profile. A `seg_done` pulse on the last profile returns `profile_sel` to 0, and `burst_done` never rises.
- R8: `force_ramp_up` is 1 exactly when the sequencer is engaged, that is when `ram_mode` is 1 and the captured code lies from 3'b001 to 3'b110.
- R9: While `ram_mode` is 0, the block is disengaged (pass-through, `force_ramp_up` 0, `burst_done` 0), `seg_done` is ignored, and the profile position is kept for when `ram_mode` returns.
- R10: A strobe that arrives after a single burst has completed restarts the order from profile 0.
- R11: When `update_strobe` and `seg_done` are both 1 in the same cycle, the strobe takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_mode | input | 1 | High when the engine runs from RAM |
| ctrl_code | input | 3 | Sequencer control code, captured on the strobe |
| update_strobe | input | 1 | One-cycle update strobe |
| seg_done | input | 1 | Pulse from the address generator when the segment final address is reached |
| ext_profile | input | 2 | External profile-select pins |
| profile_sel | output | 2 | Profile in use |
| force_ramp_up | output | 1 | Forces every segment to run as ramp-up |
| burst_done | output | 1 | Single burst complete |

## Verification
The directed patterns cover the following cases:
- A full two-profile single burst, to show that the select holds on the last profile and that completion comes only after the last segment.
- A three-profile loop, to show the wrap to 0 and that completion never rises while looping.
- The invalid code 3'b111, to show that it behaves like 3'b000.
- A code change without a strobe, to show that the code is captured only on the strobe.
- A strobe and a segment pulse in the same cycle, to show that the strobe wins.
- A drop out of RAM mode, to show that the position is kept and segment pulses are ignored.

Random stimulus then mixes all codes, strobes, segment pulses, pin values and RAM-mode changes, and each output is compared every cycle with a bench model. This tells apart wrong last-profile limits, a wrong choice between single and looping order, and leaks of the external pins while the sequencer is engaged.

// File: rtl/profile_burst_seq.sv
module profile_burst_seq #(
  parameter int PW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ram_mode,
  input  logic [CW-1:0] ctrl_code,
  input  logic          update_strobe,
  input  logic          seg_done,
  input  logic [PW-1:0] ext_profile,
  output logic [PW-1:0] profile_sel,
  output logic          force_ramp_up,
  output logic          burst_done
);
  logic [CW-1:0] code_q;
  logic [PW-1:0] prof_q;
  logic          done_q;

  wire           code_ok = (code_q != '0) && (code_q != {CW{1'b1}});
  wire           engaged = ram_mode && code_ok;
  wire           looping = code_q[CW-1];
  wire [PW-1:0]  last_prof = looping ? PW'(code_q[PW-1:0] + 1'b1) : code_q[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      prof_q <= '0;
      done_q <= 1'b0;
    end else if (update_strobe) begin
      code_q <= ctrl_code;
      prof_q <= '0;
      done_q <= 1'b0;
    end else if (engaged && seg_done && !done_q) begin
      if (prof_q != last_prof)
        prof_q <= prof_q + 1'b1;
      else if (looping)
        prof_q <= '0;
      else
        done_q <= 1'b1;
    end
  end

  assign profile_sel   = engaged ? prof_q : ext_profile;
  assign force_ramp_up = engaged;
  assign burst_done    = engaged && done_q;
endmodule

module profile_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ram_mode,
  input logic [2:0] ctrl_code,
  input logic       update_strobe,
  input logic       seg_done,
  input logic [1:0] ext_profile,
  input logic [1:0] profile_sel,
  input logic       force_ramp_up,
  input logic       burst_done
);
  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !force_ramp_up |-> (profile_sel == ext_profile && !burst_done));

  assert_no_ram_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_mode |-> !force_ramp_up);

  assert_start_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (update_strobe && ctrl_code != 3'b000 && ctrl_code != 3'b111)
      |=> (!ram_mode || (force_ramp_up && profile_sel == 2'd0 && !burst_done)));

  assert_invalid_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (update_strobe && (ctrl_code == 3'b000 || ctrl_code == 3'b111)) |=> !force_ramp_up);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !update_strobe) |=> (!ram_mode || (burst_done && $stable(profile_sel))));

  assert_hold_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ramp_up && !update_strobe && !seg_done)
      |=> (!ram_mode || (force_ramp_up && $stable(profile_sel))));
endmodule

bind profile_burst_seq profile_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ram_mode(ram_mode), .ctrl_code(ctrl_code),
  .update_strobe(update_strobe), .seg_done(seg_done), .ext_profile(ext_profile),
  .profile_sel(profile_sel), .force_ramp_up(force_ramp_up), .burst_done(burst_done)
);

// File: tb/test_profile_burst_seq.sv
module test_profile_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ram_mode = 1;
  logic [2:0] ctrl_code = 0;
  logic       update_strobe = 0;
  logic       seg_done = 0;
  logic [1:0] ext_profile = 0;
  logic [1:0] profile_sel;
  logic       force_ramp_up;
  logic       burst_done;

  int checks = 0;
  int fails = 0;

  logic [2:0] m_code = 0;
  logic [1:0] m_prof = 0;
  logic       m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  profile_burst_seq i_profile_burst_seq (
    .clk(clk), .rst_n(rst_n), .ram_mode(ram_mode), .ctrl_code(ctrl_code),
    .update_strobe(update_strobe), .seg_done(seg_done), .ext_profile(ext_profile),
    .profile_sel(profile_sel), .force_ramp_up(force_ramp_up), .burst_done(burst_done)
  );

  function automatic logic m_engaged();
    return ram_mode && m_code != 3'b000 && m_code != 3'b111;
  endfunction

  function automatic logic [1:0] m_last(input logic [2:0] c);
    case (c)
      3'b001, 3'b100: return 2'd1;
      3'b010, 3'b101: return 2'd2;
      default:        return 2'd3;
    endcase
  endfunction

  task automatic model_edge(input logic rm, input logic [2:0] cc, input logic us, input logic sd);
    logic eng;
    eng = rm && m_code != 3'b000 && m_code != 3'b111;
    if (us) begin
      m_code = cc; m_prof = 0; m_done = 0;
    end else if (eng && sd && !m_done) begin
      if (m_prof != m_last(m_code)) m_prof = m_prof + 1'b1;
      else if (m_code[2]) m_prof = 0;
      else m_done = 1;
    end
  endtask

  task automatic check(input string req);
    logic [1:0] es;
    logic ef, ed;
    ef = m_engaged();
    es = ef ? m_prof : ext_profile;
    ed = ef && m_done;
    checks++;
    if (profile_sel !== es || force_ramp_up !== ef || burst_done !== ed) begin
      fails++;
      $display("FAIL %s: sel/force/done = %0d/%0b/%0b expected %0d/%0b/%0b",
               req, profile_sel, force_ramp_up, burst_done, es, ef, ed);
    end
  endtask

  function automatic string auto_req();
    if (!ram_mode) return "R9";
    if (m_code == 3'b000 || m_code == 3'b111) return "R2";
    if (m_done) return "R6";
    if (m_code[2]) return "R7";
    return "R5";
  endfunction

  task automatic cyc(input logic rm, input logic [2:0] cc, input logic us,
                     input logic sd, input logic [1:0] ep, input string req);
    ram_mode = rm; ctrl_code = cc; update_strobe = us; seg_done = sd; ext_profile = ep;
    @(posedge clk);
    model_edge(rm, cc, us, sd);
    #1;
    update_strobe = 0; seg_done = 0;
    #1;
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    ext_profile = 2'd2;
    #(CLK_PERIOD * 2 + 1);
    check("R1");
    rst_n = 1;
    #1;
    check("R1");

    // R4 R5 R6: two-profile single burst
    cyc(1, 3'b001, 1, 0, 2'd3, "R4");
    cyc(1, 3'b000, 0, 1, 2'd3, "R5");
    cyc(1, 3'b000, 0, 0, 2'd3, "R5");
    cyc(1, 3'b000, 0, 1, 2'd3, "R6");
    cyc(1, 3'b000, 0, 1, 2'd0, "R6");
    // R10 restart
    cyc(1, 3'b001, 1, 0, 2'd3, "R10");
    // R7 three-profile loop
    cyc(1, 3'b101, 1, 0, 2'd1, "R4");
    for (int i = 0; i < 7; i++) cyc(1, 3'b000, 0, 1, 2'd1, "R7");
    // R3: code change without strobe
    cyc(1, 3'b111, 0, 0, 2'd1, "R3");
    cyc(1, 3'b011, 0, 0, 2'd1, "R3");
    // R11: strobe and segment pulse together
    cyc(1, 3'b110, 1, 1, 2'd2, "R11");
    cyc(1, 3'b110, 0, 1, 2'd2, "R5");
    // R9: leave RAM mode
    cyc(0, 3'b110, 0, 1, 2'd3, "R9");
    cyc(0, 3'b110, 0, 1, 2'd0, "R9");
    cyc(1, 3'b110, 0, 0, 2'd0, "R9");
    // R2: invalid code
    cyc(1, 3'b111, 1, 0, 2'd3, "R2");
    cyc(1, 3'b111, 0, 1, 2'd1, "R2");
    cyc(1, 3'b000, 1, 0, 2'd2, "R2");

    for (int i = 0; i < 4000; i++) begin
      logic rm, us, sd;
      logic [2:0] cc;
      logic [1:0] ep;
      rm = ($urandom % 10) != 0;
      us = ($urandom % 12) == 0;
      sd = ($urandom % 3) == 0;
      cc = 3'($urandom % 8);
      ep = 2'($urandom % 4);
      ram_mode = rm; ctrl_code = cc; update_strobe = us; seg_done = sd; ext_profile = ep;
      @(posedge clk);
      model_edge(rm, cc, us, sd);
      #1;
      update_strobe = 0; seg_done = 0;
      #1;
      check(us ? "R4" : (auto_req() == "R5" ? "R8" : auto_req()));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule